// File: doc/BRIEF.md
# Nibble-Mode Reverse Byte Receiver

This block is the host side of an IEEE 1284 reverse channel running in nibble mode, used once the link has already been negotiated into that mode. The peripheral has no way to drive the data bus back to the host, so it returns each byte four bits at a time over its status lines. The receiver drives the host handshake line to request a nibble, waits for the peripheral's acknowledge strobe, latches the four status lines and then waits for the strobe to be released. Two such handshakes build one byte: the low half first, then the high half.

A transfer starts with a one-cycle `start` pulse together with a byte count. Each finished byte is offered on a valid/ready output. The block waits until the byte is taken before it asks for the next nibble. A one-cycle `done` pulse ends every transfer, and `xfer_count` then holds the number of bytes that were handed over. Two sticky flags report how a transfer stopped early: `err_timeout` and `err_io`.

Every wait on the acknowledge line has a limit counted in clock cycles. A generous idle limit covers the first nibble of a byte, because the peripheral may have no data ready yet. A short response limit covers every other wait. All peripheral inputs pass through a synchronizer `SYNC_STAGES` flops deep before the control logic sees them.

Top module: `nib_rev_rx`

## Requirements
- R1: Out of reset, `host_nautofd` is high, `rx_valid`, `done`, `err_timeout` and `err_io` are low, and `xfer_count` is 0. `host_nselectin` and `host_nstrobe` stay high at all times.
- R2: A `start` pulse with a non-zero `byte_count` drives `host_nautofd` low on the following clock edge. This is the request for the first nibble.
- R3: When the synchronized acknowledge line is seen low during a request, the block raises `host_nautofd` on that edge and latches the status lines as a nibble: fault line to bit 0, select line to bit 1, paper-error line to bit 2 and busy line to bit 3. Each line is taken at its pin level.
- R4: The first nibble of a byte fills `rx_data[3:0]`. The second nibble fills `rx_data[7:4]` with the same line order and leaves the low half unchanged.
- R5: After each capture the block requests nothing more until it sees the acknowledge line high again.
- R6: An assembled byte stays on `rx_data` with `rx_valid` high and unchanged until `rx_ready` is high. While `rx_valid` is high, `host_nautofd` stays high. The next request is issued on the edge that accepts the byte.
- R7: The wait for the acknowledge line to go low on the first nibble of a byte lasts at most `IDLE_LIMIT` cycles. If it expires, the transfer ends with `done` and `err_timeout`.
- R8: The wait for the acknowledge line to go low on the second nibble lasts at most `RESP_LIMIT` cycles. If it expires, the transfer ends with `err_timeout`.
- R9: Each wait for the acknowledge line to return high lasts at most `RESP_LIMIT` cycles. Expiry after the second nibble ends the transfer with `err_io`. Expiry after the first nibble ends it with `err_timeout`. The two flags are never high together.
- R10: `done` is a single-cycle pulse. It fires on the edge that accepts the last byte, or on the edge of an expiry. With `done`, `xfer_count` equals the number of bytes accepted. A `byte_count` of 0 gives `done` on the edge after `start`, with a count of 0.
- R11: A `start` pulse during a transfer is ignored: the transfer goes on with its original byte count.
- R12: A new `start` clears `err_timeout` and `err_io` on the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins a transfer |
| byte_count | input | CNT_W | Number of bytes to receive, latched at start |
| pin_nack | input | 1 | Peripheral acknowledge strobe, active low |
| pin_nfault | input | 1 | Peripheral fault line, nibble bit 0 |
| pin_select | input | 1 | Peripheral select line, nibble bit 1 |
| pin_perror | input | 1 | Peripheral paper-error line, nibble bit 2 |
| pin_busy | input | 1 | Peripheral busy line, nibble bit 3 |
| host_nautofd | output | 1 | Host request/acknowledge line, low requests a nibble |
| host_nselectin | output | 1 | Host select line, held high |
| host_nstrobe | output | 1 | Host strobe line, held high |
| rx_data | output | 8 | Assembled byte |
| rx_valid | output | 1 | Byte on rx_data is valid |
| rx_ready | input | 1 | Consumer accepts the byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_timeout | output | 1 | Transfer ended on an expired wait (timeout class) |
| err_io | output | 1 | Transfer ended on an expired release wait after the second nibble |
| xfer_count | output | CNT_W | Bytes accepted in the current or last transfer |

## Verification
The nibble path is driven with the bytes 0x00, 0xFF, 0xA5, 0x3C, 0x96, 0x5A, 0xC3, 0x0F and 0xF0. All-zero and all-ones catch stuck bits. The alternating and half-filled values catch a swapped line order or swapped nibble halves.

A fast responsive peripheral is compared against a slow one that holds the consumer's ready low for stretches. This separates the handshake ordering from the hold-until-accepted rule. A first-nibble delay that fits the idle limit but not the response limit shows whether the right limit is applied to each wait.

Four stalled-peripheral runs each stop at a different wait. Together they tell apart the timeout and I/O error classes and the byte count reported for each. A zero-byte request and a start pulse during a transfer cover the remaining control cases.

// File: rtl/nib_rev_pkg.sv
package nib_rev_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_LO = 2'd1,
    ST_WAIT_HI = 2'd2,
    ST_HOLD    = 2'd3
  } rx_state_e;

  // Synchronized peripheral lines, packed in pin order.
  typedef struct packed {
    logic nack;
    logic nfault;
    logic select;
    logic perror;
    logic busy;
  } line_set_t;

  localparam int LINE_W = 5;

  // Fault -> bit 0, select -> bit 1, paper error -> bit 2, busy -> bit 3.
  function automatic logic [3:0] lines_to_nibble(line_set_t l);
    return {l.busy, l.perror, l.select, l.nfault};
  endfunction

endpackage

// File: rtl/nib_rev_sync.sv
module nib_rev_sync #(
  parameter int              W       = 5,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/nib_rev_wdog.sv
module nib_rev_wdog #(
  parameter int IDLE_LIMIT = 2000,
  parameter int RESP_LIMIT = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic long_sel,
  output logic expired
);

  localparam int MAX_LIM = (IDLE_LIMIT > RESP_LIMIT) ? IDLE_LIMIT : RESP_LIMIT;
  localparam int CW      = $clog2(MAX_LIM + 1);
  localparam logic [CW-1:0] LONG_END  = CW'(IDLE_LIMIT - 1);
  localparam logic [CW-1:0] SHORT_END = CW'(RESP_LIMIT - 1);
  localparam logic [CW-1:0] SAT_END   = CW'(MAX_LIM - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)        cnt_q <= '0;
    else if (cnt_q != SAT_END) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == (long_sel ? LONG_END : SHORT_END));

  AST_WDOG_CAP: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < MAX_LIM); // R7

endmodule

// File: rtl/nib_rev_pack.sv
module nib_rev_pack (
  input  logic       clk,
  input  logic       rst,
  input  logic       cap,
  input  logic       hi,
  input  logic [3:0] nib,
  output logic [7:0] byte_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
    end else if (cap) begin
      if (hi) byte_q[7:4] <= nib;
      else    byte_q[3:0] <= nib;
    end
  end

  AST_PACK_KEEP_LOW: assert property (@(posedge clk) disable iff (rst)
    cap && hi |=> byte_q[3:0] == $past(byte_q[3:0])); // R4

endmodule

// File: rtl/nib_rev_rx.sv
module nib_rev_rx #(
  parameter int CNT_W       = 8,
  parameter int IDLE_LIMIT  = 2000,
  parameter int RESP_LIMIT  = 60,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             pin_nack,
  input  logic             pin_nfault,
  input  logic             pin_select,
  input  logic             pin_perror,
  input  logic             pin_busy,
  output logic             host_nautofd,
  output logic             host_nselectin,
  output logic             host_nstrobe,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             done,
  output logic             err_timeout,
  output logic             err_io,
  output logic [CNT_W-1:0] xfer_count
);
  import nib_rev_pkg::*;

  localparam logic [LINE_W-1:0] LINES_IDLE = '1;

  rx_state_e        state_q, st_nx;
  logic             phase_q;
  logic             naf_q, valid_q, done_q, eto_q, eio_q;
  logic [CNT_W-1:0] cnt_q, total_q, cnt_inc;
  logic [LINE_W-1:0] raw_vec, ln_vec;
  line_set_t        ln;
  logic             tmr_clr, tmr_long, tmr_exp;
  logic             cap_en, last_byte;

  assign raw_vec = {pin_nack, pin_nfault, pin_select, pin_perror, pin_busy};

  nib_rev_sync #(.W(LINE_W), .STAGES(SYNC_STAGES), .RST_VAL(LINES_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_vec),
    .q   (ln_vec)
  );

  assign ln = line_set_t'(ln_vec);

  nib_rev_wdog #(.IDLE_LIMIT(IDLE_LIMIT), .RESP_LIMIT(RESP_LIMIT)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .clear    (tmr_clr),
    .long_sel (tmr_long),
    .expired  (tmr_exp)
  );

  assign cap_en = (state_q == ST_WAIT_LO) && !ln.nack;

  nib_rev_pack u_pack (
    .clk    (clk),
    .rst    (rst),
    .cap    (cap_en),
    .hi     (phase_q),
    .nib    (lines_to_nibble(ln)),
    .byte_q (rx_data)
  );

  assign cnt_inc   = cnt_q + 1'b1;
  assign last_byte = (cnt_inc == total_q);

  always_comb begin
    st_nx = state_q;
    unique case (state_q)
      ST_IDLE:    if (start && byte_count != '0) st_nx = ST_WAIT_LO;
      ST_WAIT_LO: begin
        if (!ln.nack)    st_nx = ST_WAIT_HI;
        else if (tmr_exp) st_nx = ST_IDLE;
      end
      ST_WAIT_HI: begin
        if (ln.nack)      st_nx = phase_q ? ST_HOLD : ST_WAIT_LO;
        else if (tmr_exp) st_nx = ST_IDLE;
      end
      ST_HOLD:    if (rx_ready) st_nx = last_byte ? ST_IDLE : ST_WAIT_LO;
      default:    st_nx = ST_IDLE;
    endcase
  end

  assign tmr_clr  = (st_nx != state_q) || (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign tmr_long = (state_q == ST_WAIT_LO) && !phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      naf_q   <= 1'b1;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      eto_q   <= 1'b0;
      eio_q   <= 1'b0;
      cnt_q   <= '0;
      total_q <= '0;
    end else begin
      state_q <= st_nx;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            eto_q   <= 1'b0;
            eio_q   <= 1'b0;
            cnt_q   <= '0;
            total_q <= byte_count;
            phase_q <= 1'b0;
            if (byte_count == '0) done_q <= 1'b1;
            else                  naf_q  <= 1'b0;
          end
        end
        ST_WAIT_LO: begin
          if (!ln.nack) begin
            naf_q <= 1'b1;
          end else if (tmr_exp) begin
            naf_q  <= 1'b1;
            eto_q  <= 1'b1;
            done_q <= 1'b1;
          end
        end
        ST_WAIT_HI: begin
          if (ln.nack) begin
            if (!phase_q) begin
              phase_q <= 1'b1;
              naf_q   <= 1'b0;
            end else begin
              valid_q <= 1'b1;
            end
          end else if (tmr_exp) begin
            done_q <= 1'b1;
            if (phase_q) eio_q <= 1'b1;
            else         eto_q <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (rx_ready) begin
            valid_q <= 1'b0;
            cnt_q   <= cnt_inc;
            if (last_byte) begin
              done_q <= 1'b1;
            end else begin
              phase_q <= 1'b0;
              naf_q   <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign host_nautofd   = naf_q;
  assign host_nselectin = 1'b1;
  assign host_nstrobe   = 1'b1;
  assign rx_valid       = valid_q;
  assign done           = done_q;
  assign err_timeout    = eto_q;
  assign err_io         = eio_q;
  assign xfer_count     = cnt_q;

  AST_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> host_nautofd); // R6

  AST_VALID_STABLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R6

  AST_RAISE_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(host_nautofd) && !done |-> !$past(ln.nack)); // R3

  AST_REQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(host_nautofd) && phase_q |-> $past(ln.nack)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_XFER_BOUND: assert property (@(posedge clk) disable iff (rst)
    xfer_count <= total_q); // R10

  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(err_timeout && err_io)); // R9

endmodule

// File: tb/nib_rev_rx_bench.sv
module nib_rev_rx_bench;

  localparam int CW  = 8;
  localparam int IDL = 200;
  localparam int RSP = 24;
  localparam int NS  = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] byte_count = '0;
  logic          pin_nack = 1'b1, pin_nfault = 1'b1, pin_select = 1'b1;
  logic          pin_perror = 1'b1, pin_busy = 1'b1;
  logic          rx_ready = 1'b1;
  logic          host_nautofd, host_nselectin, host_nstrobe;
  logic [7:0]    rx_data;
  logic          rx_valid, done, err_timeout, err_io;
  logic [CW-1:0] xfer_count;

  nib_rev_rx #(.CNT_W(CW), .IDLE_LIMIT(IDL), .RESP_LIMIT(RSP), .SYNC_STAGES(NS)) u_nib_rev_rx (
    .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
    .pin_nack(pin_nack), .pin_nfault(pin_nfault), .pin_select(pin_select),
    .pin_perror(pin_perror), .pin_busy(pin_busy),
    .host_nautofd(host_nautofd), .host_nselectin(host_nselectin), .host_nstrobe(host_nstrobe),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .done(done), .err_timeout(err_timeout), .err_io(err_io), .xfer_count(xfer_count)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;

  // peripheral configuration (written by the stimulus process only)
  logic [7:0] src[$];
  int dly0 = 2, dly1 = 2, rel = 2, stall_lo = -1, stall_hi = -1, rdy_mode = 0;
  int p_gen = 0;
  // peripheral state (written by the clock process only)
  int p_seen = 0, p_idx = 0, p_wait = 0;
  logic [7:0] got[$];

  // behavioural reference of the receiver
  int         m_st = 0, m_tmr = 0, m_cnt = 0, m_tot = 0;
  bit         m_ph = 0, m_af = 1, m_valid = 0, m_done = 0, m_eto = 0, m_eio = 0, m_live = 0;
  logic [7:0] m_data = '0;
  logic [4:0] hist[$];

  task automatic check(input int act, input int exp, input string req, input string what);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_all();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic model_step(input logic [4:0] v);
    logic [3:0] nib;
    nib = {v[0], v[1], v[2], v[3]};
    if (rst) begin
      m_st = 0; m_tmr = 0; m_cnt = 0; m_tot = 0; m_ph = 0; m_af = 1;
      m_valid = 0; m_done = 0; m_eto = 0; m_eio = 0; m_data = '0;
      return;
    end
    m_done = 0;
    case (m_st)
      0: if (start) begin
        m_eto = 0; m_eio = 0; m_cnt = 0; m_tot = int'(byte_count); m_ph = 0; m_tmr = 0;
        if (byte_count == 0) m_done = 1;
        else begin m_af = 0; m_st = 1; end
      end
      1: if (!v[4]) begin
        if (!m_ph) m_data[3:0] = nib; else m_data[7:4] = nib;
        m_af = 1; m_st = 2; m_tmr = 0;
      end else if (m_tmr == (m_ph ? RSP : IDL) - 1) begin
        m_eto = 1; m_done = 1; m_af = 1; m_st = 0; m_tmr = 0;
      end else m_tmr++;
      2: if (v[4]) begin
        m_tmr = 0;
        if (!m_ph) begin m_ph = 1; m_af = 0; m_st = 1; end
        else begin m_valid = 1; m_st = 3; end
      end else if (m_tmr == RSP - 1) begin
        if (m_ph) m_eio = 1; else m_eto = 1;
        m_done = 1; m_st = 0; m_tmr = 0;
      end else m_tmr++;
      default: if (rx_ready) begin
        m_valid = 0; m_cnt++;
        if (m_cnt == m_tot) begin m_done = 1; m_st = 0; end
        else begin m_ph = 0; m_af = 0; m_st = 1; end
      end
    endcase
  endtask

  always @(negedge clk) begin
    logic [4:0] v;
    logic [7:0] b;
    cyc++;
    if (cyc > 150000) begin
      check(0, 1, "R10", "watchdog expired");
      finish_all();
    end
    if (m_live) begin
      check(int'(host_nautofd), int'(m_af), "R2", "request line");
      check(int'(host_nselectin), 1, "R1", "select-in line");
      check(int'(host_nstrobe), 1, "R1", "strobe line");
      check(int'(rx_valid), int'(m_valid), "R6", "rx_valid");
      check(int'(rx_data), int'(m_data), "R4", "rx_data");
      check(int'(done), int'(m_done), "R10", "done");
      check(int'(err_timeout), int'(m_eto), "R7", "err_timeout");
      check(int'(err_io), int'(m_eio), "R9", "err_io");
      check(int'(xfer_count), m_cnt, "R10", "xfer_count");
    end
    // peripheral
    if (p_seen != p_gen) begin
      p_seen = p_gen; p_idx = 0; p_wait = 0; pin_nack = 1'b1;
    end else if (!rst) begin
      if (pin_nack && !host_nautofd) begin
        if (p_idx != stall_lo) begin
          if (p_wait >= ((p_idx % 2) ? dly1 : dly0)) begin
            b = (p_idx / 2 < src.size()) ? src[p_idx / 2] : 8'h00;
            if (p_idx % 2) b = b >> 4;
            pin_nfault = b[0]; pin_select = b[1]; pin_perror = b[2]; pin_busy = b[3];
            pin_nack = 1'b0; p_wait = 0; p_idx++;
          end else p_wait++;
        end
      end else if (!pin_nack && host_nautofd) begin
        if (p_idx - 1 != stall_hi) begin
          if (p_wait >= rel) begin pin_nack = 1'b1; p_wait = 0; end
          else p_wait++;
        end
      end else p_wait = 0;
    end
    rx_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 7) >= 4);
    if (!rst && rx_valid && rx_ready) got.push_back(rx_data);
    hist.push_back(rst ? 5'h1f : {pin_nack, pin_nfault, pin_select, pin_perror, pin_busy});
    v = (hist.size() > NS) ? hist[hist.size() - 1 - NS] : 5'h1f;
    while (hist.size() > NS + 1) hist = hist[1:$];
    model_step(v);
    m_live = 1;
  end

  task automatic run(input int n, input int exp_cnt, input int exp_eto, input int exp_eio,
                     input bit mid_start, input string req);
    int k;
    @(posedge clk); #1;
    got.delete();
    p_gen++;
    repeat (6) @(posedge clk);
    #1 start = 1'b1; byte_count = CW'(n);
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    check(int'(err_timeout), 0, "R12", "timeout flag cleared by start");
    check(int'(err_io), 0, "R12", "io flag cleared by start");
    if (n != 0) check(int'(host_nautofd), 0, "R2", "first request after start");
    if (mid_start) begin
      repeat (30) @(posedge clk);
      #1 start = 1'b1; byte_count = 8'd1;
      @(posedge clk); #1 start = 1'b0;
    end
    k = 0;
    while (!done && k < 8000) begin @(negedge clk); k++; end
    check(int'(done), 1, req, "done reached");
    check(int'(xfer_count), exp_cnt, req, "bytes delivered");
    check(int'(err_timeout), exp_eto, req, "timeout flag");
    check(int'(err_io), exp_eio, req, "io flag");
    check(got.size(), exp_cnt, req, "bytes seen at output");
    for (int i = 0; i < exp_cnt && i < got.size(); i++)
      check(int'(got[i]), int'(src[i]), "R4", "byte value");
    @(negedge clk);
    check(int'(done), 0, "R10", "done is one cycle");
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(int'(host_nautofd), 1, "R1", "reset request line");
    check(int'(rx_valid), 0, "R1", "reset valid");
    check(int'(done), 0, "R1", "reset done");
    check(int'(xfer_count), 0, "R1", "reset count");
    check(int'(err_timeout) + int'(err_io), 0, "R1", "reset error flags");

    // R3 R4: five patterns, fast peripheral
    src = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h96};
    run(5, 5, 0, 0, 0, "R3");
    // R6 R5: slow peripheral, ready throttled
    src = '{8'h5A, 8'hC3, 8'h0F, 8'hF0};
    dly0 = 40; dly1 = 10; rel = 8; rdy_mode = 1;
    run(4, 4, 0, 0, 0, "R6");
    dly0 = 2; dly1 = 2; rel = 2; rdy_mode = 0;
    // R10: zero-length request
    run(0, 0, 0, 0, 0, "R10");
    // R11: start during a transfer is ignored
    src = '{8'h11, 8'h22, 8'h33};
    run(3, 3, 0, 0, 1, "R11");
    // R7: first nibble of byte 1 never acknowledged
    src = '{8'h7E, 8'h81, 8'h42};
    stall_lo = 2;
    run(3, 1, 1, 0, 0, "R7");
    // R8: second nibble of byte 0 never acknowledged
    stall_lo = 1;
    run(3, 0, 1, 0, 0, "R8");
    stall_lo = -1;
    // R9: release never comes after the second nibble of byte 1
    stall_hi = 3;
    run(3, 1, 0, 1, 0, "R9");
    // R9: release never comes after the first nibble of byte 0
    stall_hi = 0;
    run(3, 0, 1, 0, 0, "R9");
    stall_hi = -1;
    // R7 R8 boundary: slow first nibble fits idle limit only
    src = '{8'hE1, 8'h6B};
    dly0 = 150; dly1 = 18;
    run(2, 2, 0, 0, 0, "R7");
    repeat (4) @(posedge clk);
    finish_all();
  end

endmodule